// File: doc/BRIEF.md
# OFDM Cyclic Prefix Remover

This block sits in the sample stream just before a 64-point FFT in an OFDM receiver. Every OFDM symbol is 80 samples long, and its first 16 samples are a guard copy that the FFT must not see. The block does not buffer or reorder anything. It registers the complex samples straight through and masks the valid qualifier, so that only the 64 useful samples of each symbol reach the FFT as valid.

A position counter tracks where the current sample sits inside its symbol. The counter moves only on cycles that carry a valid sample, so gaps in the input stream do not shift the guard window. A symbol-start marker, taken together with a valid sample, sets the counter back to the first guard position. This marker can realign the block at any time. The block also flags the first and the last forwarded sample of each FFT frame.

Top module: `cp_strip`

## Requirements
- R1: After a synchronous reset, out_valid, out_sof and out_eof are low. The block forwards nothing until it sees a sample that has both in_valid and in_sym_start high.
- R2: Before the first sample with in_sym_start high after reset, out_valid stays low whatever in_valid does.
- R3: A sample taken with in_valid=1 and in_sym_start=1 is symbol position 0. Positions 0 to 15 produce out_valid=0 and positions 16 to 79 produce out_valid=1. The result appears on the outputs one clock after the sample is presented.
- R4: In an uninterrupted valid stream that starts with a symbol start, out_valid repeats with a period of 80 samples: 16 low, then 64 high. Exactly 64 samples per symbol are forwarded, and the sample after a frame end is never forwarded.
- R5: The position advances only on cycles with in_valid=1. A cycle with in_valid=0 gives out_valid=0 and leaves the position unchanged.
- R6: in_sym_start has no effect on a cycle with in_valid=0.
- R7: in_sym_start with in_valid=1 in the middle of a symbol restarts the count at position 0 on that sample.
- R8: out_i and out_q equal in_i and in_q from one clock earlier, on every cycle, whether the sample is forwarded or not.
- R9: out_sof is high only with the sample at position 16, and out_eof only with the sample at position 79. Both occur only while out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_sym_start | input | 1 | Marks the current valid sample as the first guard sample of a symbol |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| out_valid | output | 1 | High for forwarded (non-guard) samples |
| out_sof | output | 1 | First forwarded sample of an FFT frame |
| out_eof | output | 1 | Last forwarded sample of an FFT frame |
| out_i | output | DW | Registered in-phase sample |
| out_q | output | DW | Registered quadrature sample |

## Verification
The assertions assume that reset is held high from time zero until the first clock edges have passed. They also assume that the symbol-start marker only counts when it arrives with a valid sample. Within those limits they check relations that must hold for any input stream, so the marker may arrive at any point in the stream. The stimulus keeps reset asserted at the start. It then drives the stream from a segment table that mixes gap patterns, realignments, and markers placed on invalid cycles. Directed cases cover reset in the middle of a frame and a stream that has no start marker.

// File: rtl/cp_strip.sv
module cp_strip #(
  parameter int DW    = 16,
  parameter int GUARD = 16,
  parameter int NFFT  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sym_start,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic                 out_eof,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int SYM = GUARD + NFFT;
  localparam int PW  = $clog2(SYM);
  localparam logic [PW-1:0] LAST  = PW'(SYM - 1);
  localparam logic [PW-1:0] FIRST = PW'(GUARD);

  logic [PW-1:0] pos;
  logic          locked;
  logic [PW-1:0] pos_nx;
  logic          lock_nx;
  logic          fwd;

  assign pos_nx  = in_sym_start ? '0 : (pos == LAST) ? '0 : pos + 1'b1;
  assign lock_nx = locked | in_sym_start;
  assign fwd     = in_valid & lock_nx & (pos_nx >= FIRST);

  always_ff @(posedge clk) begin
    out_i <= in_i;
    out_q <= in_q;
    if (rst) begin
      pos       <= LAST;
      locked    <= 1'b0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      if (in_valid) begin
        pos    <= pos_nx;
        locked <= lock_nx;
      end
      out_valid <= fwd;
      out_sof   <= fwd & (pos_nx == FIRST);
      out_eof   <= fwd & (pos_nx == LAST);
    end
  end

  a_r9_sof_in_frame: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  a_r9_eof_in_frame: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid);
  a_r5_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r3_start_is_guard: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sym_start) |=> (!out_valid && !out_sof));
  a_r4_gap_after_eof: assert property (@(posedge clk) disable iff (rst)
    out_eof |=> !out_valid);
  a_r8_data_delay: assert property (@(posedge clk) disable iff (rst)
    (out_i == $past(in_i)) && (out_q == $past(in_q)));
endmodule

// File: tb/cp_strip_bench.sv
module cp_strip_bench;
  localparam int DW = 16;
  localparam int NSEG = 6;
  // segment: valid samples, gap period (0 = none), sym_start on first sample, sym_start without valid in middle
  localparam int SEG_N  [NSEG] = '{160, 120, 50, 200, 90, 100};
  localparam int SEG_GAP[NSEG] = '{0,   3,   0,  5,   2,  0};
  localparam int SEG_SS [NSEG] = '{1,   0,   1,  0,   1,  0};
  localparam int SEG_INV[NSEG] = '{0,   1,   0,  0,   1,  0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sym_start = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic out_valid, out_sof, out_eof;
  logic signed [DW-1:0] out_i, out_q;

  int total = 0, bad = 0;
  int m_pos = 79;
  bit m_lock = 0;
  int fwd_cnt;
  bit done = 0;
  logic signed [DW-1:0] last_i, last_q;

  always #10 clk = ~clk;

  cp_strip #(.DW(DW)) u_cp_strip (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym_start(in_sym_start),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .out_i(out_i), .out_q(out_q));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit s, input string tag);
    bit ev, es, ee;
    @(negedge clk);
    in_valid = v; in_sym_start = s;
    in_i = DW'($urandom); in_q = DW'($urandom);
    last_i = in_i; last_q = in_q;
    if (v) begin
      if (s) begin m_pos = 0; m_lock = 1; end
      else if (m_lock) m_pos = (m_pos + 1) % 80;
    end
    ev = v && m_lock && (m_pos >= 16);
    es = ev && m_pos == 16;
    ee = ev && m_pos == 79;
    @(posedge clk);
    #1;
    chk(out_valid == ev, tag, out_valid, ev);
    chk(out_sof == es, "R9 sof", out_sof, es);
    chk(out_eof == ee, "R9 eof", out_eof, ee);
    chk(out_i == last_i && out_q == last_q, "R8 data", out_i, last_i);
    if (out_valid) fwd_cnt++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_sym_start = 0;
    @(posedge clk); @(posedge clk);
    #1;
    chk(!out_valid && !out_sof && !out_eof, "R1 reset", {out_valid, out_sof, out_eof}, 0);
    @(negedge clk);
    rst = 0;
    m_pos = 79; m_lock = 0;
  endtask

  initial begin
    do_reset();
    for (int k = 0; k < 100; k++) step(1'b1, 1'b0, "R2 no start");
    chk(fwd_cnt == 0, "R2 count", fwd_cnt, 0);

    for (int sg = 0; sg < NSEG; sg++) begin
      int sent = 0;
      fwd_cnt = 0;
      while (sent < SEG_N[sg]) begin
        if (SEG_GAP[sg] != 0 && (sent % SEG_GAP[sg]) == SEG_GAP[sg] - 1 && sent != 0) begin
          step(1'b0, SEG_INV[sg] != 0, "R5/R6 gap");
          sent += 0;
        end
        step(1'b1, (sent == 0 && SEG_SS[sg] != 0), "R3 mask");
        sent++;
        if (SEG_GAP[sg] != 0 && (sent % SEG_GAP[sg]) == SEG_GAP[sg] - 1)
          step(1'b0, SEG_INV[sg] != 0, "R5/R6 gap");
      end
      if (sg == 0) chk(fwd_cnt == 128, "R4 two symbols", fwd_cnt, 128);
    end

    // R7: realign in the middle of a frame
    step(1'b1, 1'b1, "R7 start");
    for (int k = 0; k < 30; k++) step(1'b1, 1'b0, "R7 run");
    step(1'b1, 1'b1, "R7 realign");
    fwd_cnt = 0;
    for (int k = 0; k < 79; k++) step(1'b1, 1'b0, "R7 after");
    chk(fwd_cnt == 64, "R7 count", fwd_cnt, 64);

    // R6: start marker on invalid cycle does not realign
    step(1'b0, 1'b1, "R6 ignored");
    fwd_cnt = 0;
    for (int k = 0; k < 80; k++) step(1'b1, 1'b0, "R6 after");
    chk(fwd_cnt == 64, "R6 count", fwd_cnt, 64);

    // reset mid-frame, then wait for a new start
    do_reset();
    for (int k = 0; k < 40; k++) step(1'b1, 1'b0, "R1 wait");
    step(1'b1, 1'b1, "R1 restart");
    for (int k = 0; k < 90; k++) step(1'b1, 1'b0, "R4 run");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule